// File: doc/BRIEF.md
# Fetch-and-Execute Control Sequencer

This block is the control sequencer of a small 16-bit datapath organised around one shared internal bus. It fetches each instruction from external memory with a valid-address / ready handshake and captures the returned word in an instruction register. It then decodes the word and either updates the program counter directly or runs a register-to-register ALU operation in several steps.

An ALU operation first stages one source register in a holding operand register. It then places the second source on the bus next to the ALU and keeps the ALU result in an output register. Only in a later cycle does it write that result to the destination register.

The register file and the ALU sit outside the block. The sequencer drives their read address, write strobe and operation code, and takes their data back as inputs. The internal bus has three possible drivers: memory, the register file and the output register. Each driver has an enable, and at most one enable is active in any cycle.

Top module: `ctrl_seq`

## Requirements
- R1: While reset is held and after its release, the PC is 0, the memory valid strobe is low, no bus source is enabled and no register write occurs. The first fetch reads address 0.
- R2: During a fetch, the memory address equals the PC, the read/write line is 0 (read) and the valid strobe is 1.
- R3: While the valid strobe is high and ready is low, the sequencer keeps the valid strobe high and the address unchanged, for any number of wait cycles.
- R4: In the cycle after ready is sampled high with the valid strobe high, the instruction register holds the word that was on the memory data input, and the valid strobe is low.
- R5: Instruction fields are: opcode in [15:12], destination in [11:9], first source in [8:6], second source in [5:3]. Opcodes 1 to 5 select add, subtract (first minus second), and, or and xor. They drive the ALU operation code 0 to 4 respectively, and the result is written to the destination register.
- R6: An ALU instruction reads the first source into the operand register, then the second source, then writes the output register back in a separate cycle. It makes exactly one register write. A destination equal to a source gets the result computed from the old values.
- R7: Opcode 6 is a jump. The PC is loaded with bits [11:0] zero-extended, the next fetch uses that address, and no register is written.
- R8: Opcode 0 and opcodes 7 to 15 write no register and only advance the PC by 1.
- R9: After an ALU instruction writes back, the PC advances by 1.
- R10: Bus enables are one-hot or zero: bit 0 selects memory, bit 1 the register file and bit 2 the output register. The memory enable is set only while the valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | AW | Memory address from the address register |
| mem_rw_o | output | 1 | Read/write line, 0 for read |
| mem_vma_o | output | 1 | Memory address valid strobe |
| mem_ready_i | input | 1 | Memory data ready |
| mem_data_i | input | DW | Memory read data |
| rf_raddr_o | output | 3 | Register file read address |
| rf_rdata_i | input | DW | Register file read data |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 3 | Register file write address |
| rf_wdata_o | output | DW | Register file write data (bus value) |
| alu_op_o | output | 3 | ALU operation code |
| alu_a_o | output | DW | ALU first operand (operand register) |
| alu_b_o | output | DW | ALU second operand (bus value) |
| alu_y_i | input | DW | ALU result |
| bus_oe_o | output | 3 | Bus source enables |
| pc_o | output | AW | Program counter |
| ir_o | output | DW | Instruction register |

## Verification
Several rules are checked on every cycle: the handshake rules (the address stays put and the strobe stays up through the wait, and the strobe drops after ready), instruction capture, address-equals-PC during a fetch, the one-hot bus enables, single-cycle write strobes and the PC step after writeback. Only the bench scenarios can show the rest. These are the arithmetic results landing in the right destination, with subtraction order and the source-equals-destination case, the jump target and the fetch order it produces, and unknown opcodes leaving every register untouched. The bench runs the same program with zero and with several wait cycles of memory latency.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;
  localparam int RAW  = 3;
  localparam int TGTW = 12;
  localparam int NSRC = 3;
  localparam int BUS_MEM = 0;
  localparam int BUS_RF  = 1;
  localparam int BUS_OUT = 2;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_WAIT,
    ST_DECODE,
    ST_EXEC_OP1,
    ST_EXEC_OP2,
    ST_WRITEBACK
  } st_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    IC_NOP,
    IC_ALU,
    IC_JMP
  } iclass_e;

  typedef struct packed {
    iclass_e          cls;
    alu_op_e          op;
    logic [RAW-1:0]   rd;
    logic [RAW-1:0]   rs1;
    logic [RAW-1:0]   rs2;
    logic [TGTW-1:0]  tgt;
  } dec_t;
endpackage

// File: rtl/ctrl_seq_dec.sv
module ctrl_seq_dec
  import ctrl_seq_pkg::*;
(
  input  logic [15:0] ir_i,
  output dec_t        dec_o
);
  logic [3:0] opc;
  assign opc = ir_i[15:12];

  always_comb begin
    dec_o.rd  = ir_i[11:9];
    dec_o.rs1 = ir_i[8:6];
    dec_o.rs2 = ir_i[5:3];
    dec_o.tgt = ir_i[TGTW-1:0];
    dec_o.cls = IC_NOP;
    dec_o.op  = ALU_ADD;
    unique case (opc)
      4'd1: begin dec_o.cls = IC_ALU; dec_o.op = ALU_ADD; end
      4'd2: begin dec_o.cls = IC_ALU; dec_o.op = ALU_SUB; end
      4'd3: begin dec_o.cls = IC_ALU; dec_o.op = ALU_AND; end
      4'd4: begin dec_o.cls = IC_ALU; dec_o.op = ALU_OR;  end
      4'd5: begin dec_o.cls = IC_ALU; dec_o.op = ALU_XOR; end
      4'd6: dec_o.cls = IC_JMP;
      default: dec_o.cls = IC_NOP;
    endcase
  end
endmodule

// File: rtl/ctrl_seq_fsm.sv
module ctrl_seq_fsm
  import ctrl_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ready_i,
  input  iclass_e         cls_i,
  output logic            vma_o,
  output logic [NSRC-1:0] bus_oe_o,
  output logic            addr_ld_o,
  output logic            ir_ld_o,
  output logic            pc_inc_o,
  output logic            pc_jmp_o,
  output logic            opreg_ld_o,
  output logic            outreg_ld_o,
  output logic            rf_we_o,
  output logic            rs_sel_o
);
  st_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    vma_o       = 1'b0;
    bus_oe_o    = '0;
    addr_ld_o   = 1'b0;
    ir_ld_o     = 1'b0;
    pc_inc_o    = 1'b0;
    pc_jmp_o    = 1'b0;
    opreg_ld_o  = 1'b0;
    outreg_ld_o = 1'b0;
    rf_we_o     = 1'b0;
    rs_sel_o    = 1'b0;
    unique case (state_q)
      ST_FETCH_ADDR: begin
        addr_ld_o = 1'b1;
        state_d   = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: begin
        vma_o             = 1'b1;
        bus_oe_o[BUS_MEM] = 1'b1;
        if (ready_i) begin
          ir_ld_o = 1'b1;
          state_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        unique case (cls_i)
          IC_ALU: state_d = ST_EXEC_OP1;
          IC_JMP: begin pc_jmp_o = 1'b1; state_d = ST_FETCH_ADDR; end
          default: begin pc_inc_o = 1'b1; state_d = ST_FETCH_ADDR; end
        endcase
      end
      ST_EXEC_OP1: begin
        bus_oe_o[BUS_RF] = 1'b1;
        opreg_ld_o       = 1'b1;
        state_d          = ST_EXEC_OP2;
      end
      ST_EXEC_OP2: begin
        bus_oe_o[BUS_RF] = 1'b1;
        rs_sel_o         = 1'b1;
        outreg_ld_o      = 1'b1;
        state_d          = ST_WRITEBACK;
      end
      ST_WRITEBACK: begin
        bus_oe_o[BUS_OUT] = 1'b1;
        rf_we_o           = 1'b1;
        pc_inc_o          = 1'b1;
        state_d           = ST_FETCH_ADDR;
      end
      default: state_d = ST_FETCH_ADDR;
    endcase
  end
endmodule

// File: rtl/ctrl_seq_pcu.sv
module ctrl_seq_pcu
  import ctrl_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_ld_i,
  input  logic            pc_inc_i,
  input  logic            pc_jmp_i,
  input  logic [TGTW-1:0] tgt_i,
  input  logic            ir_ld_i,
  input  logic [DW-1:0]   bus_i,
  output logic [AW-1:0]   pc_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   ir_o
);
  localparam logic [AW-1:0] PC_STEP = AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= '0;
      addr_o <= '0;
      ir_o   <= '0;
    end else begin
      if (pc_jmp_i)      pc_o <= AW'(tgt_i);
      else if (pc_inc_i) pc_o <= pc_o + PC_STEP;
      if (addr_ld_i)     addr_o <= pc_o;
      if (ir_ld_i)       ir_o   <= bus_i;
    end
  end
endmodule

// File: rtl/ctrl_seq_stage.sv
module ctrl_seq_stage
  import ctrl_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] bus_oe_i,
  input  logic [DW-1:0]   mem_data_i,
  input  logic [DW-1:0]   rf_data_i,
  input  logic [DW-1:0]   alu_y_i,
  input  logic            opreg_ld_i,
  input  logic            outreg_ld_i,
  output logic [DW-1:0]   bus_o,
  output logic [DW-1:0]   opreg_o
);
  logic [DW-1:0] outreg_q;
  logic [DW-1:0] src   [NSRC];
  logic [DW-1:0] gated [NSRC];
  logic [DW-1:0] acc   [NSRC+1];

  assign src[BUS_MEM] = mem_data_i;
  assign src[BUS_RF]  = rf_data_i;
  assign src[BUS_OUT] = outreg_q;

  // enable-gated OR models the shared tri-state bus
  assign acc[0] = '0;
  for (genvar g = 0; g < NSRC; g++) begin : g_bus
    assign gated[g]  = src[g] & {DW{bus_oe_i[g]}};
    assign acc[g+1]  = acc[g] | gated[g];
  end
  assign bus_o = acc[NSRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opreg_o  <= '0;
      outreg_q <= '0;
    end else begin
      if (opreg_ld_i)  opreg_o  <= bus_o;
      if (outreg_ld_i) outreg_q <= alu_y_i;
    end
  end
endmodule

// File: rtl/ctrl_seq.sv
module ctrl_seq
  import ctrl_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_rw_o,
  output logic            mem_vma_o,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_data_i,
  output logic [RAW-1:0]  rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic [2:0]      alu_op_o,
  output logic [DW-1:0]   alu_a_o,
  output logic [DW-1:0]   alu_b_o,
  input  logic [DW-1:0]   alu_y_i,
  output logic [NSRC-1:0] bus_oe_o,
  output logic [AW-1:0]   pc_o,
  output logic [DW-1:0]   ir_o
);
  dec_t          dec;
  logic          addr_ld, ir_ld, pc_inc, pc_jmp;
  logic          opreg_ld, outreg_ld, rs_sel;
  logic [DW-1:0] bus;

  ctrl_seq_dec u_dec (
    .ir_i  (ir_o[15:0]),
    .dec_o (dec)
  );

  ctrl_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (mem_ready_i),
    .cls_i       (dec.cls),
    .vma_o       (mem_vma_o),
    .bus_oe_o    (bus_oe_o),
    .addr_ld_o   (addr_ld),
    .ir_ld_o     (ir_ld),
    .pc_inc_o    (pc_inc),
    .pc_jmp_o    (pc_jmp),
    .opreg_ld_o  (opreg_ld),
    .outreg_ld_o (outreg_ld),
    .rf_we_o     (rf_we_o),
    .rs_sel_o    (rs_sel)
  );

  ctrl_seq_pcu #(.AW(AW), .DW(DW)) u_pcu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_ld_i (addr_ld),
    .pc_inc_i  (pc_inc),
    .pc_jmp_i  (pc_jmp),
    .tgt_i     (dec.tgt),
    .ir_ld_i   (ir_ld),
    .bus_i     (bus),
    .pc_o      (pc_o),
    .addr_o    (mem_addr_o),
    .ir_o      (ir_o)
  );

  ctrl_seq_stage #(.DW(DW)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_oe_i    (bus_oe_o),
    .mem_data_i  (mem_data_i),
    .rf_data_i   (rf_rdata_i),
    .alu_y_i     (alu_y_i),
    .opreg_ld_i  (opreg_ld),
    .outreg_ld_i (outreg_ld),
    .bus_o       (bus),
    .opreg_o     (alu_a_o)
  );

  assign mem_rw_o   = 1'b0;  // sequencer only issues reads
  assign rf_raddr_o = rs_sel ? dec.rs2 : dec.rs1;
  assign rf_waddr_o = dec.rd;
  assign rf_wdata_o = bus;
  assign alu_b_o    = bus;
  assign alu_op_o   = dec.op;
endmodule

// File: rtl/ctrl_seq_chk.sv
module ctrl_seq_chk #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_vma_o,
  input logic          mem_ready_i,
  input logic [DW-1:0] mem_data_i,
  input logic          rf_we_o,
  input logic [2:0]    bus_oe_o,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] ir_o
);
  a_r2_addr_is_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_vma_o |-> mem_addr_o == pc_o);

  a_r3_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_vma_o && !mem_ready_i) |=> (mem_vma_o && $stable(mem_addr_o)));

  a_r4_vma_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_vma_o && mem_ready_i) |=> !mem_vma_o);

  a_r4_ir_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_vma_o && mem_ready_i) |=> ir_o == $past(mem_data_i));

  a_r6_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);

  a_r6_write_from_outreg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> bus_oe_o == 3'b100);

  a_r9_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> pc_o == $past(pc_o) + AW'(1));

  a_r10_bus_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_oe_o));
endmodule

bind ctrl_seq ctrl_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_vma_o   (mem_vma_o),
  .mem_ready_i (mem_ready_i),
  .mem_data_i  (mem_data_i),
  .rf_we_o     (rf_we_o),
  .bus_oe_o    (bus_oe_o),
  .pc_o        (pc_o),
  .ir_o        (ir_o)
);

// File: tb/ctrl_seq_bench.sv
`timescale 1ns/1ps
module ctrl_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rw, mem_vma;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_data = '0;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic [2:0]  alu_op;
  logic [15:0] alu_a, alu_b, alu_y;
  logic [2:0]  bus_oe;
  logic [15:0] pc, ir;

  int nchk = 0, nerr = 0, cyc = 0;
  int lat = 0, wcnt = 0, nfetch = 0, nwr = 0;
  int r2_err = 0, r3_err = 0, r4_err = 0, r10_err = 0;
  bit run = 0, hs_q = 0, wait_q = 0;
  logic [15:0] addr_q;
  logic [15:0] mem [64];
  logic [15:0] rf [8];
  logic [15:0] trace [16];

  always #2.5 clk = ~clk;

  ctrl_seq u_ctrl_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_rw_o(mem_rw), .mem_vma_o(mem_vma),
    .mem_ready_i(mem_ready), .mem_data_i(mem_data),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .alu_op_o(alu_op), .alu_a_o(alu_a), .alu_b_o(alu_b), .alu_y_i(alu_y),
    .bus_oe_o(bus_oe), .pc_o(pc), .ir_o(ir)
  );

  assign rf_rdata = rf[rf_raddr];

  always_comb begin
    case (alu_op)
      3'd0: alu_y = alu_a + alu_b;
      3'd1: alu_y = alu_a - alu_b;
      3'd2: alu_y = alu_a & alu_b;
      3'd3: alu_y = alu_a | alu_b;
      3'd4: alu_y = alu_a ^ alu_b;
      default: alu_y = 16'hdead;
    endcase
  end

  always @(posedge clk) begin
    if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
      nwr = nwr + 1;
    end
  end

  // memory model and protocol monitor, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      if (hs_q && mem_vma) r4_err++;
      if (wait_q && (!mem_vma || mem_addr != addr_q)) r3_err++;
      if (mem_vma && mem_rw) r2_err++;
      if (!$onehot0(bus_oe) || (bus_oe[0] && !mem_vma)) r10_err++;
      if (mem_vma) begin
        if (wcnt >= lat) begin
          mem_ready = 1'b1;
          mem_data  = mem[mem_addr[5:0]];
          if (nfetch < 16) trace[nfetch] = mem_addr;
          nfetch++;
        end else begin
          mem_ready = 1'b0;
          wcnt++;
        end
      end else begin
        mem_ready = 1'b0;
        wcnt = 0;
      end
      hs_q   = mem_vma && mem_ready;
      wait_q = mem_vma && !mem_ready;
      addr_q = mem_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int opc, input int rd, input int s1, input int s2);
    return {4'(opc), 3'(rd), 3'(s1), 3'(s2), 3'b000};
  endfunction

  task automatic load_prog();
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    mem[0]  = enc(1, 3, 1, 2);    // add
    mem[1]  = enc(2, 4, 1, 2);    // sub
    mem[2]  = enc(3, 5, 1, 2);    // and
    mem[3]  = enc(4, 6, 1, 2);    // or
    mem[4]  = enc(5, 7, 1, 2);    // xor
    mem[5]  = 16'h6010;           // jump 0x010
    mem[16] = enc(1, 1, 1, 1);    // r1 = r1 + r1
    mem[17] = enc(15, 3, 1, 2);   // unknown opcode
    mem[18] = 16'h0000;           // nop
    mem[19] = 16'h6013;           // jump to self
  endtask

  task automatic do_reset(input int l);
    run = 0; rst_ni = 1'b0; mem_ready = 1'b0;
    lat = l; wcnt = 0; nfetch = 0; nwr = 0;
    r2_err = 0; r3_err = 0; r4_err = 0; r10_err = 0;
    hs_q = 0; wait_q = 0;
    for (int i = 0; i < 8; i++) rf[i] = 16'h0000;
    rf[1] = 16'h1234; rf[2] = 16'h0F0F;
    load_prog();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(0);
    chk(pc == 16'h0, "R1 pc in reset", 32'(pc), 0);
    chk(mem_vma == 1'b0, "R1 vma in reset", 32'(mem_vma), 0);
    chk(bus_oe == 3'b000, "R1 bus idle in reset", 32'(bus_oe), 0);
    chk(rf_we == 1'b0, "R1 no write in reset", 32'(rf_we), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_vma == 1'b1, "R2 vma on first fetch", 32'(mem_vma), 1);
    chk(mem_addr == 16'h0, "R1 first fetch address", 32'(mem_addr), 0);
    chk(mem_rw == 1'b0, "R2 read on fetch", 32'(mem_rw), 0);
  endtask

  task automatic t_program(input int l);
    logic [15:0] exp_tr [12];
    int guard = 0;
    exp_tr = '{16'h0, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5,
               16'h10, 16'h11, 16'h12, 16'h13, 16'h13, 16'h13};
    do_reset(l);
    rst_ni = 1'b1;
    run = 1;
    while (nfetch < 12 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "R3 progress under latency", 32'(guard), 2000);
    repeat (4) @(negedge clk);
    run = 0;
    for (int i = 0; i < 12; i++)
      chk(trace[i] == exp_tr[i], "R7 R8 R9 fetch order", 32'(trace[i]), 32'(exp_tr[i]));
    chk(rf[3] == 16'h2143, "R5 add result", 32'(rf[3]), 32'h2143);
    chk(rf[4] == 16'h0325, "R5 sub order", 32'(rf[4]), 32'h0325);
    chk(rf[5] == 16'h0204, "R5 and result", 32'(rf[5]), 32'h0204);
    chk(rf[6] == 16'h1F3F, "R5 or result", 32'(rf[6]), 32'h1F3F);
    chk(rf[7] == 16'h1D3B, "R5 xor result", 32'(rf[7]), 32'h1D3B);
    chk(rf[1] == 16'h2468, "R6 dest equals source", 32'(rf[1]), 32'h2468);
    chk(rf[2] == 16'h0F0F, "R8 source untouched", 32'(rf[2]), 32'h0F0F);
    chk(nwr == 6, "R6 R7 R8 write count", 32'(nwr), 6);
    chk(pc == 16'h0013, "R7 pc at jump target", 32'(pc), 32'h13);
    chk(r2_err == 0, "R2 read line during fetch", 32'(r2_err), 0);
    chk(r3_err == 0, "R3 hold while waiting", 32'(r3_err), 0);
    chk(r4_err == 0, "R4 vma drop after ready", 32'(r4_err), 0);
    chk(r10_err == 0, "R10 single bus source", 32'(r10_err), 0);
  endtask

  initial begin
    t_reset();
    t_program(0);
    t_program(3);
    t_program(7);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule